// File: doc/BRIEF.md
# Microprogrammed Accumulator Computer

This block is a small 16-bit accumulator machine. A control store drives its control path one microinstruction per clock. It holds a word-addressed main memory and four registers: an accumulator, a data register, an 11-bit address register and an 11-bit program counter. The control store is a 128-word, 20-bit read-only table. A microsequencer steps through it, with a control address register and a one-level return register.

Every machine instruction runs the same sequence. First a shared fetch routine runs. Then the sequencer jumps to a four-word routine at four times the opcode. If the instruction requests indirection, that routine first calls a shared subroutine that replaces the operand address with the low 11 bits of the word it points at. Only four opcodes are implemented. Every other opcode runs as a no-op.

Memory is loaded, and read back, through a debug port while reset is held. After reset is released the machine fetches its first instruction from address 0. The accumulator and the program counter can be observed at all times.

Top module: `mcpu_top`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator and the program counter both go to 0. After reset is released, the first instruction is fetched from memory address 0.
- R2: An instruction word has three fields. Bit 15 is the indirect flag, bits 14..11 are the opcode, and bits 10..0 are the operand address.
- R3: Opcode 0 (add) sets AC to AC + M[EA], truncated to 16 bits. PC then points at the next word.
- R4: When bit 15 is set, the effective address is bits 10..0 of M[addr]. When bit 15 is clear, the effective address is addr. This holds for all four implemented opcodes.
- R5: Opcode 2 (store) writes AC into M[EA] and leaves AC unchanged.
- R6: Opcode 3 (exchange) swaps the contents of AC and M[EA].
- R7: Opcode 1 (branch) sets PC to EA when AC bit 15 is 1. When AC bit 15 is 0 it only advances PC by one. PC changes only in these two ways.
- R8: Opcodes 4 to 15 leave AC and memory unchanged and advance PC by one.
- R9: Each instruction takes a fixed number of cycles, fetch included:
  - add: 6 cycles
  - branch not taken: 5 cycles
  - branch taken: 6 cycles
  - store: 6 cycles
  - exchange: 7 cycles
  - unused opcode: 4 cycles
  - indirection: 2 extra cycles.
  The add result appears in AC on the instruction's last edge.
- R10: `dbg_we` writes `dbg_wdata` to `dbg_addr` only while `rst` is high. At other times it has no effect. `dbg_rdata` shows the word at `dbg_addr` one clock later.
- R11: The sequencer's map step enters control address opcode×4. A call saves the next control address, and a return resumes at that saved address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; enables debug writes |
| dbg_we | input | 1 | Debug memory write enable (honoured only in reset) |
| dbg_addr | input | 11 | Debug read/write address |
| dbg_wdata | input | 16 | Debug write data |
| dbg_rdata | output | 16 | Registered debug read data |
| ac_out | output | 16 | Accumulator |
| pc_out | output | 11 | Program counter |

## Verification
A wrong control address or a corrupted return register shows up within a few cycles. The cycle count of an instruction changes, or AC or PC settles on a wrong value at the next instruction boundary. The bench samples exactly at those boundaries, one cycle apart. A data-path slip, such as a swapped exchange, a write to the wrong address or a skipped indirection, leaves a wrong word in memory. That word is read back through the debug port while reset is held. Branch decisions show immediately as a wrong PC after the branch instruction.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;
  localparam int DW   = 16;
  localparam int AW   = 11;
  localparam int OPW  = 4;
  localparam int CAW  = 7;
  localparam int UFW  = 3;

  typedef enum logic [1:0] {CD_ONE, CD_IND, CD_NEG, CD_ZERO} cond_e;
  typedef enum logic [1:0] {BR_JMP, BR_CALL, BR_RET, BR_MAP} br_e;

  typedef struct packed {
    logic [UFW-1:0] f1;
    logic [UFW-1:0] f2;
    logic [UFW-1:0] f3;
    cond_e          cd;
    br_e            br;
    logic [CAW-1:0] ad;
  } uword_t;

  localparam logic [CAW-1:0] FETCH_ENTRY = 7'd64;
  localparam logic [CAW-1:0] INDIR_ENTRY = 7'd67;

  // group 1 micro-ops
  localparam logic [2:0] U1_NOP = 3'd0, U1_ADD = 3'd1, U1_CLRAC = 3'd2, U1_INCAC = 3'd3,
                         U1_DR2AC = 3'd4, U1_DR2AR = 3'd5, U1_PC2AR = 3'd6, U1_WRITE = 3'd7;
  // group 2 micro-ops
  localparam logic [2:0] U2_NOP = 3'd0, U2_SUB = 3'd1, U2_OR = 3'd2, U2_AND = 3'd3,
                         U2_READ = 3'd4, U2_AC2DR = 3'd5, U2_INCDR = 3'd6, U2_PC2DR = 3'd7;
  // group 3 micro-ops
  localparam logic [2:0] U3_NOP = 3'd0, U3_XOR = 3'd1, U3_COM = 3'd2, U3_SHL = 3'd3,
                         U3_SHR = 3'd4, U3_INCPC = 3'd5, U3_AR2PC = 3'd6;
endpackage

// File: rtl/mcpu_ctrl_rom.sv
module mcpu_ctrl_rom
  import mcpu_pkg::*;
(
  input  logic [CAW-1:0] car,
  output uword_t         uw
);
  function automatic uword_t mk(logic [2:0] f1, logic [2:0] f2, logic [2:0] f3,
                                cond_e cd, br_e br, logic [CAW-1:0] ad);
    mk = '{f1: f1, f2: f2, f3: f3, cd: cd, br: br, ad: ad};
  endfunction

  function automatic uword_t rom_word(logic [CAW-1:0] a);
    case (a)
      // add
      7'd0:  rom_word = mk(U1_NOP, U2_NOP, U3_NOP, CD_IND, BR_CALL, INDIR_ENTRY);
      7'd1:  rom_word = mk(U1_NOP, U2_READ, U3_NOP, CD_ONE, BR_JMP, 7'd2);
      7'd2:  rom_word = mk(U1_ADD, U2_NOP, U3_NOP, CD_ONE, BR_JMP, FETCH_ENTRY);
      // branch on negative accumulator
      7'd4:  rom_word = mk(U1_NOP, U2_NOP, U3_NOP, CD_NEG, BR_JMP, 7'd6);
      7'd5:  rom_word = mk(U1_NOP, U2_NOP, U3_NOP, CD_ONE, BR_JMP, FETCH_ENTRY);
      7'd6:  rom_word = mk(U1_NOP, U2_NOP, U3_NOP, CD_IND, BR_CALL, INDIR_ENTRY);
      7'd7:  rom_word = mk(U1_NOP, U2_NOP, U3_AR2PC, CD_ONE, BR_JMP, FETCH_ENTRY);
      // store
      7'd8:  rom_word = mk(U1_NOP, U2_NOP, U3_NOP, CD_IND, BR_CALL, INDIR_ENTRY);
      7'd9:  rom_word = mk(U1_NOP, U2_AC2DR, U3_NOP, CD_ONE, BR_JMP, 7'd10);
      7'd10: rom_word = mk(U1_WRITE, U2_NOP, U3_NOP, CD_ONE, BR_JMP, FETCH_ENTRY);
      // exchange
      7'd12: rom_word = mk(U1_NOP, U2_NOP, U3_NOP, CD_IND, BR_CALL, INDIR_ENTRY);
      7'd13: rom_word = mk(U1_NOP, U2_READ, U3_NOP, CD_ONE, BR_JMP, 7'd14);
      7'd14: rom_word = mk(U1_DR2AC, U2_AC2DR, U3_NOP, CD_ONE, BR_JMP, 7'd15);
      7'd15: rom_word = mk(U1_WRITE, U2_NOP, U3_NOP, CD_ONE, BR_JMP, FETCH_ENTRY);
      // fetch and decode
      7'd64: rom_word = mk(U1_PC2AR, U2_NOP, U3_NOP, CD_ONE, BR_JMP, 7'd65);
      7'd65: rom_word = mk(U1_NOP, U2_READ, U3_INCPC, CD_ONE, BR_JMP, 7'd66);
      7'd66: rom_word = mk(U1_DR2AR, U2_NOP, U3_NOP, CD_ONE, BR_MAP, '0);
      // indirection subroutine
      7'd67: rom_word = mk(U1_NOP, U2_READ, U3_NOP, CD_ONE, BR_JMP, 7'd68);
      7'd68: rom_word = mk(U1_DR2AR, U2_NOP, U3_NOP, CD_ONE, BR_RET, '0);
      // every other word returns to fetch
      default: rom_word = mk(U1_NOP, U2_NOP, U3_NOP, CD_ONE, BR_JMP, FETCH_ENTRY);
    endcase
  endfunction

  always_comb uw = rom_word(car);
endmodule

// File: rtl/mcpu_sequencer.sv
module mcpu_sequencer
  import mcpu_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  uword_t         uw,
  input  logic           ind_bit,
  input  logic           ac_neg,
  input  logic           ac_zero,
  input  logic [OPW-1:0] opcode,
  output logic [CAW-1:0] car,
  output logic [CAW-1:0] sbr,
  output logic           cond
);
  localparam int PADW = CAW - OPW - 2;
  logic [CAW-1:0] car_inc;

  always_comb begin
    case (uw.cd)
      CD_ONE:  cond = 1'b1;
      CD_IND:  cond = ind_bit;
      CD_NEG:  cond = ac_neg;
      default: cond = ac_zero;
    endcase
    car_inc = car + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car <= FETCH_ENTRY;
      sbr <= '0;
    end else begin
      case (uw.br)
        BR_JMP:  car <= cond ? uw.ad : car_inc;
        BR_CALL: begin
          car <= cond ? uw.ad : car_inc;
          if (cond) sbr <= car_inc;
        end
        BR_RET:  car <= sbr;
        default: car <= {{PADW{1'b0}}, opcode, 2'b00};
      endcase
    end
  end
endmodule

// File: rtl/mcpu_datapath.sv
module mcpu_datapath
  import mcpu_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rst,
  input  uword_t            uw,
  input  logic              dbg_we,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic [DATA_W-1:0] ac,
  output logic [DATA_W-1:0] dr,
  output logic [ADDR_W-1:0] ar,
  output logic [ADDR_W-1:0] pc
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [0:DEPTH-1];
  logic [DATA_W-1:0] rd_data, ac_n, dr_n;
  logic [ADDR_W-1:0] ar_n, pc_n, wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              wr_en;

  assign rd_data = mem[ar];
  assign wr_en   = rst ? dbg_we    : (uw.f1 == U1_WRITE);
  assign wr_addr = rst ? dbg_addr  : ar;
  assign wr_data = rst ? dbg_wdata : dr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    dbg_rdata <= mem[dbg_addr];
  end

  // accumulator: group 1 overrides group 2, which overrides group 3
  always_comb begin
    ac_n = ac;
    case (uw.f3)
      U3_XOR:  ac_n = ac ^ dr;
      U3_COM:  ac_n = ~ac;
      U3_SHL:  ac_n = {ac[DATA_W-2:0], 1'b0};
      U3_SHR:  ac_n = {1'b0, ac[DATA_W-1:1]};
      default: ;
    endcase
    case (uw.f2)
      U2_SUB:  ac_n = ac - dr;
      U2_OR:   ac_n = ac | dr;
      U2_AND:  ac_n = ac & dr;
      default: ;
    endcase
    case (uw.f1)
      U1_ADD:   ac_n = ac + dr;
      U1_CLRAC: ac_n = '0;
      U1_INCAC: ac_n = ac + 1'b1;
      U1_DR2AC: ac_n = dr;
      default:  ;
    endcase
  end

  always_comb begin
    dr_n = dr;
    case (uw.f2)
      U2_READ:  dr_n = rd_data;
      U2_AC2DR: dr_n = ac;
      U2_INCDR: dr_n = dr + 1'b1;
      U2_PC2DR: dr_n = {dr[DATA_W-1:ADDR_W], pc};
      default:  ;
    endcase
    ar_n = ar;
    if (uw.f1 == U1_DR2AR) ar_n = dr[ADDR_W-1:0];
    else if (uw.f1 == U1_PC2AR) ar_n = pc;
    pc_n = pc;
    if (uw.f3 == U3_INCPC) pc_n = pc + 1'b1;
    else if (uw.f3 == U3_AR2PC) pc_n = ar;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ac <= '0;
      dr <= '0;
      ar <= '0;
      pc <= '0;
    end else begin
      ac <= ac_n;
      dr <= dr_n;
      ar <= ar_n;
      pc <= pc_n;
    end
  end
endmodule

// File: rtl/mcpu_top.sv
module mcpu_top
  import mcpu_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_we,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic [DATA_W-1:0] ac_out,
  output logic [ADDR_W-1:0] pc_out
);
  uword_t         uw;
  logic [CAW-1:0] car, sbr;
  logic           cond;
  logic [DATA_W-1:0] ac_q, dr_q;
  logic [ADDR_W-1:0] ar_q, pc_q;
  logic [OPW-1:0] opcode;

  assign opcode = dr_q[DATA_W-2 -: OPW];

  mcpu_ctrl_rom u_rom (.car(car), .uw(uw));

  mcpu_sequencer u_seq (
    .clk(clk), .rst(rst), .uw(uw),
    .ind_bit(dr_q[DATA_W-1]), .ac_neg(ac_q[DATA_W-1]), .ac_zero(ac_q == '0),
    .opcode(opcode), .car(car), .sbr(sbr), .cond(cond)
  );

  mcpu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .uw(uw),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .ac(ac_q), .dr(dr_q), .ar(ar_q), .pc(pc_q)
  );

  assign ac_out = ac_q;
  assign pc_out = pc_q;
endmodule

// File: rtl/mcpu_checker.sv
module mcpu_checker
  import mcpu_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input br_e            br,
  input logic           cond,
  input logic [CAW-1:0] ad,
  input logic [CAW-1:0] car,
  input logic [CAW-1:0] sbr,
  input logic [OPW-1:0] opcode,
  input logic [AW-1:0]  pc,
  input logic [AW-1:0]  ar
);
  assert_reset_fetch_R1: assert property (@(posedge clk)
    rst |=> (car == FETCH_ENTRY && pc == '0));

  assert_map_entry_R11: assert property (@(posedge clk) disable iff (rst)
    (br == BR_MAP) |=> (car == {1'b0, $past(opcode), 2'b00}));

  assert_call_link_R11: assert property (@(posedge clk) disable iff (rst)
    (br == BR_CALL && cond) |=> (car == $past(ad) && sbr == $past(car) + 7'd1));

  assert_return_R11: assert property (@(posedge clk) disable iff (rst)
    (br == BR_RET) |=> (car == $past(sbr)));

  assert_pc_moves_R7: assert property (@(posedge clk) disable iff (rst)
    (pc != $past(pc)) |-> (pc == $past(pc) + 11'd1 || pc == $past(ar)));
endmodule

bind mcpu_top mcpu_checker u_chk (
  .clk(clk), .rst(rst), .br(uw.br), .cond(cond), .ad(uw.ad),
  .car(car), .sbr(sbr), .opcode(opcode), .pc(pc_q), .ar(ar_q)
);

// File: tb/mcpu_top_test.sv
module mcpu_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_we = 1'b0;
  logic [10:0] dbg_addr = '0;
  logic [15:0] dbg_wdata = '0;
  logic [15:0] dbg_rdata, ac_out;
  logic [10:0] pc_out;
  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  mcpu_top uut (
    .clk(clk), .rst(rst), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .ac_out(ac_out), .pc_out(pc_out)
  );

  function automatic logic [15:0] ins(logic ind, logic [3:0] op, logic [10:0] a);
    return {ind, op, a};
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_reset();
    @(negedge clk); rst = 1'b1;
    step(2);
  endtask

  task automatic poke(logic [10:0] a, logic [15:0] d);
    dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
    step(1);
    dbg_we = 1'b0;
  endtask

  task automatic peek(logic [10:0] a, output logic [15:0] d);
    dbg_addr = a;
    step(1);
    d = dbg_rdata;
  endtask

  task automatic release_reset();
    rst = 1'b0;
  endtask

  task automatic test_reset();
    logic [15:0] d;
    enter_reset();
    for (int i = 0; i < 2048; i++) poke(i[10:0], 16'h0000);
    poke(11'd0, ins(1'b0, 4'd0, 11'd1));
    poke(11'd1, 16'h0003);
    peek(11'd1, d);
    check("R10", "debug read mem[1]", d, 16'h0003);
    check("R1", "AC in reset", ac_out, 16'h0000);
    check("R1", "PC in reset", {5'd0, pc_out}, 16'h0000);
    release_reset();
    step(6);
    check("R1", "AC after first instr from addr 0", ac_out, 16'h0003);
    check("R1", "PC after first instr", {5'd0, pc_out}, 16'd1);
    enter_reset();
    check("R1", "AC cleared by reset", ac_out, 16'h0000);
    check("R1", "PC cleared by reset", {5'd0, pc_out}, 16'h0000);
  endtask

  task automatic test_add();
    enter_reset();
    poke(11'd0, ins(1'b0, 4'd0, 11'd100));
    poke(11'd1, ins(1'b1, 4'd0, 11'd101));
    poke(11'd2, ins(1'b0, 4'd0, 11'd103));
    poke(11'd100, 16'd5);
    poke(11'd101, 16'hF866);  // flag bits above address field must be ignored: EA = 102
    poke(11'd102, 16'd7);
    poke(11'd103, 16'hFFFF);
    release_reset();
    step(5);
    check("R9", "AC one cycle before add completes", ac_out, 16'h0000);
    check("R9", "PC advanced during fetch", {5'd0, pc_out}, 16'd1);
    step(1);
    check("R3", "AC after direct add", ac_out, 16'd5);
    step(7);
    check("R9", "AC before indirect add completes", ac_out, 16'd5);
    step(1);
    check("R4", "AC after indirect add (R11 call/return)", ac_out, 16'd12);
    check("R4", "PC after indirect add", {5'd0, pc_out}, 16'd2);
    step(6);
    check("R3", "AC after wrapping add", ac_out, 16'd11);
    check("R2", "PC after third add", {5'd0, pc_out}, 16'd3);
  endtask

  task automatic test_store_exchange();
    logic [15:0] d;
    enter_reset();
    poke(11'd0, ins(1'b0, 4'd0, 11'd100));
    poke(11'd1, ins(1'b0, 4'd2, 11'd200));
    poke(11'd2, ins(1'b1, 4'd2, 11'd201));
    poke(11'd3, ins(1'b0, 4'd3, 11'd103));
    poke(11'd4, ins(1'b1, 4'd3, 11'd104));
    poke(11'd100, 16'h1234);
    poke(11'd201, 16'd202);
    poke(11'd103, 16'hABCD);
    poke(11'd104, 16'd105);
    poke(11'd105, 16'h0042);
    poke(11'd300, 16'h0777);
    release_reset();
    step(6);
    dbg_we = 1'b1; dbg_addr = 11'd300; dbg_wdata = 16'hDEAD;
    step(6);
    dbg_we = 1'b0;
    check("R5", "AC unchanged by store", ac_out, 16'h1234);
    step(8);
    check("R5", "PC after indirect store", {5'd0, pc_out}, 16'd3);
    step(7);
    check("R6", "AC after direct exchange", ac_out, 16'hABCD);
    step(9);
    check("R6", "AC after indirect exchange", ac_out, 16'h0042);
    check("R4", "PC after indirect exchange", {5'd0, pc_out}, 16'd5);
    enter_reset();
    peek(11'd200, d); check("R5", "mem[200] after store", d, 16'h1234);
    peek(11'd202, d); check("R4", "mem[202] after indirect store", d, 16'h1234);
    peek(11'd103, d); check("R6", "mem[103] after exchange", d, 16'h1234);
    peek(11'd105, d); check("R6", "mem[105] after indirect exchange", d, 16'hABCD);
    peek(11'd104, d); check("R4", "pointer word untouched", d, 16'd105);
    peek(11'd300, d); check("R10", "debug write outside reset ignored", d, 16'h0777);
  endtask

  task automatic test_branch();
    logic [15:0] d;
    enter_reset();
    poke(11'd0, ins(1'b0, 4'd0, 11'd100));
    poke(11'd1, ins(1'b0, 4'd1, 11'd9));
    poke(11'd9, ins(1'b1, 4'd1, 11'd110));
    poke(11'd20, ins(1'b0, 4'd3, 11'd111));
    poke(11'd21, ins(1'b0, 4'd1, 11'd40));
    poke(11'd22, ins(1'b0, 4'd5, 11'd100));
    poke(11'd23, ins(1'b0, 4'd0, 11'd100));
    poke(11'd24, ins(1'b1, 4'd15, 11'd100));
    poke(11'd100, 16'h8000);
    poke(11'd110, 16'd20);
    poke(11'd111, 16'd1);
    release_reset();
    step(6);
    check("R3", "AC loaded negative", ac_out, 16'h8000);
    step(5);
    check("R9", "PC not yet branched at cycle 5", {5'd0, pc_out}, 16'd2);
    step(1);
    check("R7", "PC after taken direct branch", {5'd0, pc_out}, 16'd9);
    step(8);
    check("R7", "PC after taken indirect branch", {5'd0, pc_out}, 16'd20);
    step(7);
    check("R6", "AC after exchange", ac_out, 16'd1);
    step(5);
    check("R7", "PC after branch not taken", {5'd0, pc_out}, 16'd22);
    step(4);
    check("R8", "PC after opcode 5", {5'd0, pc_out}, 16'd23);
    check("R8", "AC after opcode 5", ac_out, 16'd1);
    step(6);
    check("R9", "AC after add following no-op", ac_out, 16'h8001);
    step(4);
    check("R8", "PC after opcode 15", {5'd0, pc_out}, 16'd25);
    check("R8", "AC after opcode 15", ac_out, 16'h8001);
    enter_reset();
    peek(11'd100, d); check("R8", "mem[100] untouched by no-ops", d, 16'h8000);
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_add();
    test_store_exchange();
    test_branch();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule